// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Record Queue

This block keeps the logged state of the first uncorrectable error seen by a function: a pointer to that error's bit in the uncorrectable status register, four dwords of captured request header and four dwords of captured request prefix. When software has turned on multiple-header recording, errors that arrive while the logged one is still pending wait in an in-order queue. The status register itself lives outside the block. The block sees its current value and a strobe that marks each software write to it.

A record request carries a one-hot status word, the header and prefix dwords, a header-valid flag and a prefix-present flag. When software clears the status bit of the logged error, the oldest waiting record moves into the log. While the logged error is still pending, the block returns a mask of the status bits that belong to queued records. The external register ORs that mask back in, so software cannot clear those bits early. When the queue has no room, the record is dropped and an overflow pulse is raised. Detecting errors and sending error messages are done by neighbouring logic.

Top module: `hdr_log_queue`

## Requirements
- R1: Loading a record into the log sets `fep_o` to the bit index of the single set bit of that record's status word.
- R2: On a load, header log dword k holds header input dword k with its bytes reversed (input bits 7:0 appear at log bits 31:24 of that dword). If the header-valid flag is low, the header log is zero.
- R3: On a load, if the prefix-present flag is high and `pfx_supported_i` is high, the prefix log holds the prefix dwords in the same byte-reversed order and `pfx_valid_o` is 1. Otherwise the prefix log is zero and `pfx_valid_o` is 0.
- R4: A record that arrives while `multi_en_i` is high and status bit `fep_o` is set goes into the queue, and the log outputs do not change.
- R5: A record that would be queued while the queue already holds DEPTH entries is dropped, and `overflow_o` is high for exactly one cycle.
- R6: A status write that leaves bit `fep_o` clear, with `multi_en_i` high and the queue not empty, drives `reassert_o` to the OR of the status words of every queued record (the promoted one included) and moves the oldest record into the log.
- R7: A status write that leaves bit `fep_o` clear in any other case sets `fep_o` to 0, zeroes both logs and clears `pfx_valid_o`.
- R8: A status write that leaves bit `fep_o` set, with `multi_en_i` high, drives `reassert_o` to the OR of the status words of all queued records and leaves the queue unchanged.
- R9: A status write that leaves bit `fep_o` set, with `multi_en_i` low, empties the queue, so a later write that clears the pointed bit promotes nothing.
- R10: `multi_cap_o` is 1 exactly when DEPTH is non-zero. With DEPTH 0, `multi_en_i` has no effect and every record loads the log.
- R11: The queue count never exceeds DEPTH, and records leave the queue in the order they arrived.
- R12: After reset, every log output, `reassert_o` and `overflow_o` are zero. Each output responds on the clock edge after the request, and `reassert_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid_i | input | 1 | Record request strobe |
| rec_status_i | input | STATUS_W | One-hot uncorrectable status bit of the record |
| rec_header_i | input | 128 | Four header dwords, dword k at bits 32k+31:32k |
| rec_prefix_i | input | 128 | Four prefix dwords, same layout |
| rec_hdr_valid_i | input | 1 | Header dwords are meaningful |
| rec_pfx_present_i | input | 1 | Prefix dwords are meaningful |
| multi_en_i | input | 1 | Multiple-header recording enabled by software |
| pfx_supported_i | input | 1 | Function supports end-to-end prefixes |
| sts_wr_i | input | 1 | A software write to the status register has just taken effect |
| unc_status_i | input | STATUS_W | Current uncorrectable status register value |
| fep_o | output | IDX_W | First-error pointer |
| pfx_valid_o | output | 1 | Prefix log holds a captured prefix |
| hdr_log_o | output | 128 | Header log |
| pfx_log_o | output | 128 | Prefix log |
| reassert_o | output | STATUS_W | Status bits to OR back into the status register (one-cycle pulse) |
| overflow_o | output | 1 | A record was dropped because the queue was full |
| multi_cap_o | output | 1 | Capability: multiple-header recording available |

## Verification
The assertions assume two things about the inputs: a record request and a status write never fall in the same cycle, and every record carries exactly one set status bit. The stimulus calls one task at a time, each of which holds a single strobe for one cycle, and all record status words are single-bit constants. The bench also stands in for the external status register. It sets a record's bit on the cycle after the request and ORs in its own predicted re-assert mask after each write, so the pointer bit the block tests is always the value the requirements call for.

// File: rtl/hq_pkg.sv
package hq_pkg;

  localparam int DWORD_W    = 32;
  localparam int LOG_DWORDS = 4;
  localparam int LOG_W      = DWORD_W * LOG_DWORDS;

  typedef struct packed {
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
    logic             hdr_ok;
    logic             pfx_ok;
  } payload_t;

  // Reverse the byte order inside every dword of a log
  function automatic logic [LOG_W-1:0] dword_byterev(input logic [LOG_W-1:0] d);
    logic [LOG_W-1:0] r;
    r = '0;
    for (int w = 0; w < LOG_DWORDS; w++) begin
      for (int b = 0; b < DWORD_W/8; b++) begin
        r[w*DWORD_W + (DWORD_W/8-1-b)*8 +: 8] = d[w*DWORD_W + b*8 +: 8];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/hq_fifo.sv
module hq_fifo
  import hq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int STATUS_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push,
  input  logic                             pop,
  input  logic                             flush,
  input  logic [STATUS_W-1:0]              in_status,
  input  payload_t                         in_payload,
  output logic [STATUS_W-1:0]              head_status,
  output payload_t                         head_payload,
  output logic [STATUS_W-1:0]              status_or,
  output logic                             full,
  output logic                             empty,
  output logic [$clog2(DEPTH+1)-1:0]       count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  payload_t              pay_mem [DEPTH];
  logic [STATUS_W-1:0]   st_mem  [DEPTH];
  logic [DEPTH-1:0]      live;
  logic [AW-1:0]         wr_ptr, rd_ptr;
  logic [CW-1:0]         cnt;
  logic                  do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign count   = cnt;

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) begin
      pay_mem[wr_ptr] <= in_payload;
      st_mem[wr_ptr]  <= in_status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      live   <= '0;
    end else begin
      if (do_push) begin
        wr_ptr       <= step(wr_ptr);
        live[wr_ptr] <= 1'b1;
      end
      if (do_pop) begin
        rd_ptr       <= step(rd_ptr);
        live[rd_ptr] <= 1'b0;
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_payload = pay_mem[rd_ptr];
  assign head_status  = st_mem[rd_ptr];

  always_comb begin
    status_or = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i]) status_or = status_or | st_mem[i];
    end
  end

endmodule

// File: rtl/hq_log.sv
module hq_log
  import hq_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic [STATUS_W-1:0] ld_status,
  input  payload_t            ld_payload,
  input  logic                pfx_cap,
  output logic [IDX_W-1:0]    fep,
  output logic [LOG_W-1:0]    hdr_log,
  output logic [LOG_W-1:0]    pfx_log,
  output logic                pfx_flag
);

  logic [IDX_W-1:0] idx;
  logic             take_pfx;

  // Lowest set bit wins; the record is one-hot by contract
  always_comb begin
    idx = '0;
    for (int i = STATUS_W-1; i >= 0; i--) begin
      if (ld_status[i]) idx = IDX_W'(i);
    end
  end

  assign take_pfx = ld_payload.pfx_ok && pfx_cap;

  always_ff @(posedge clk) begin
    if (rst || (clear && !load)) begin
      fep      <= '0;
      hdr_log  <= '0;
      pfx_log  <= '0;
      pfx_flag <= 1'b0;
    end else if (load) begin
      fep      <= idx;
      hdr_log  <= ld_payload.hdr_ok ? dword_byterev(ld_payload.hdr) : '0;
      pfx_log  <= take_pfx ? dword_byterev(ld_payload.pfx) : '0;
      pfx_flag <= take_pfx;
    end
  end

endmodule

// File: rtl/hdr_log_queue.sv
module hdr_log_queue
  import hq_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int DEPTH    = 8,
  localparam int IDX_W   = (STATUS_W > 1) ? $clog2(STATUS_W) : 1,
  localparam int CW      = (DEPTH > 0) ? $clog2(DEPTH+1) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rec_valid_i,
  input  logic [STATUS_W-1:0]   rec_status_i,
  input  logic [LOG_W-1:0]      rec_header_i,
  input  logic [LOG_W-1:0]      rec_prefix_i,
  input  logic                  rec_hdr_valid_i,
  input  logic                  rec_pfx_present_i,
  input  logic                  multi_en_i,
  input  logic                  pfx_supported_i,
  input  logic                  sts_wr_i,
  input  logic [STATUS_W-1:0]   unc_status_i,
  output logic [IDX_W-1:0]      fep_o,
  output logic                  pfx_valid_o,
  output logic [LOG_W-1:0]      hdr_log_o,
  output logic [LOG_W-1:0]      pfx_log_o,
  output logic [STATUS_W-1:0]   reassert_o,
  output logic                  overflow_o,
  output logic                  multi_cap_o
);

  localparam bit HAS_Q = (DEPTH > 0);

  payload_t            rec_pay, head_pay, ld_pay;
  logic [STATUS_W-1:0] head_st, q_or, ld_st;
  logic                q_full, q_empty;
  logic [CW-1:0]       q_count;
  logic                men, ptr_set;
  logic                wr_pop, wr_clear, wr_keep, wr_flush;
  logic                rec_q, rec_load, q_push, ovf_n;

  assign rec_pay  = '{hdr: rec_header_i, pfx: rec_prefix_i,
                      hdr_ok: rec_hdr_valid_i, pfx_ok: rec_pfx_present_i};

  assign men      = multi_en_i && HAS_Q;
  assign ptr_set  = unc_status_i[fep_o];

  // Software status write outcomes
  assign wr_pop   = sts_wr_i && !ptr_set && men && !q_empty;
  assign wr_clear = sts_wr_i && !ptr_set && !wr_pop;
  assign wr_keep  = sts_wr_i && ptr_set && men;
  assign wr_flush = sts_wr_i && ptr_set && !men;

  // Record outcomes; a status write wins a shared cycle
  assign rec_q    = rec_valid_i && !sts_wr_i && men && ptr_set;
  assign q_push   = rec_q && !q_full;
  assign ovf_n    = rec_q && q_full;
  assign rec_load = rec_valid_i && !sts_wr_i && !rec_q;

  assign ld_st    = wr_pop ? head_st  : rec_status_i;
  assign ld_pay   = wr_pop ? head_pay : rec_pay;

  generate
    if (HAS_Q) begin : g_queue
      hq_fifo #(
        .DEPTH    (DEPTH),
        .STATUS_W (STATUS_W)
      ) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .push         (q_push),
        .pop          (wr_pop),
        .flush        (wr_flush),
        .in_status    (rec_status_i),
        .in_payload   (rec_pay),
        .head_status  (head_st),
        .head_payload (head_pay),
        .status_or    (q_or),
        .full         (q_full),
        .empty        (q_empty),
        .count        (q_count)
      );
    end else begin : g_noq
      assign head_st  = '0;
      assign head_pay = '0;
      assign q_or     = '0;
      assign q_full   = 1'b1;
      assign q_empty  = 1'b1;
      assign q_count  = '0;
    end
  endgenerate

  hq_log #(
    .STATUS_W (STATUS_W),
    .IDX_W    (IDX_W)
  ) u_log (
    .clk        (clk),
    .rst        (rst),
    .load       (rec_load || wr_pop),
    .clear      (wr_clear),
    .ld_status  (ld_st),
    .ld_payload (ld_pay),
    .pfx_cap    (pfx_supported_i),
    .fep        (fep_o),
    .hdr_log    (hdr_log_o),
    .pfx_log    (pfx_log_o),
    .pfx_flag   (pfx_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reassert_o <= '0;
      overflow_o <= 1'b0;
    end else begin
      reassert_o <= (wr_pop || wr_keep) ? q_or : '0;
      overflow_o <= ovf_n;
    end
  end

  assign multi_cap_o = HAS_Q;

endmodule

// File: rtl/hlq_checker.sv
module hlq_checker #(
  parameter int STATUS_W = 32,
  parameter int DEPTH    = 8,
  parameter int IDX_W    = 5,
  parameter int CW       = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                rec_valid_i,
  input logic [STATUS_W-1:0] rec_status_i,
  input logic                multi_en_i,
  input logic                sts_wr_i,
  input logic [STATUS_W-1:0] unc_status_i,
  input logic [IDX_W-1:0]    fep_o,
  input logic                pfx_valid_o,
  input logic [127:0]        hdr_log_o,
  input logic [127:0]        pfx_log_o,
  input logic [STATUS_W-1:0] reassert_o,
  input logic                overflow_o,
  input logic [CW-1:0]       q_count
);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(rec_valid_i && multi_en_i && unc_status_i[fep_o]
                         && q_count == CW'(DEPTH)));

  // R12
  reassert_src_chk: assert property (@(posedge clk) disable iff (rst)
    (reassert_o != '0) |-> $past(sts_wr_i));

  // R7
  log_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sts_wr_i && !unc_status_i[fep_o] && q_count == '0)
      |-> (fep_o == '0 && hdr_log_o == '0 && pfx_log_o == '0 && !pfx_valid_o));

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sts_wr_i && unc_status_i[fep_o] && !multi_en_i) |-> q_count == '0);

  // R4
  queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_i && !sts_wr_i && multi_en_i && unc_status_i[fep_o] && DEPTH > 0)
      |=> $stable(hdr_log_o) && $stable(fep_o));

  // R1
  onehot_rec_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid_i |-> $countones(rec_status_i) == 1);

  // R12
  no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid_i && sts_wr_i));

endmodule

bind hdr_log_queue hlq_checker #(
  .STATUS_W (STATUS_W),
  .DEPTH    (DEPTH),
  .IDX_W    (IDX_W),
  .CW       (CW)
) u_chk (.*);

// File: tb/hdr_log_queue_test.sv
module hdr_log_queue_test;

  localparam int SW    = 32;
  localparam int DEPTH = 8;
  localparam int IW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           rec_valid = 0, hv = 0, pp = 0, men = 0, psup = 1, sts_wr = 0;
  logic [SW-1:0]  rec_st = '0, unc = '0;
  logic [127:0]   rec_h = '0, rec_p = '0;
  logic [IW-1:0]  fep, nq_fep;
  logic           pv, ovf, cap, nq_pv, nq_ovf, nq_cap;
  logic [127:0]   hlog, plog, nq_h, nq_p;
  logic [SW-1:0]  re, nq_re;

  hdr_log_queue #(.STATUS_W(SW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rec_valid_i(rec_valid), .rec_status_i(rec_st),
    .rec_header_i(rec_h), .rec_prefix_i(rec_p), .rec_hdr_valid_i(hv),
    .rec_pfx_present_i(pp), .multi_en_i(men), .pfx_supported_i(psup),
    .sts_wr_i(sts_wr), .unc_status_i(unc), .fep_o(fep), .pfx_valid_o(pv),
    .hdr_log_o(hlog), .pfx_log_o(plog), .reassert_o(re), .overflow_o(ovf),
    .multi_cap_o(cap));

  hdr_log_queue #(.STATUS_W(SW), .DEPTH(0)) uut_nq (
    .clk(clk), .rst(rst), .rec_valid_i(rec_valid), .rec_status_i(rec_st),
    .rec_header_i(rec_h), .rec_prefix_i(rec_p), .rec_hdr_valid_i(hv),
    .rec_pfx_present_i(pp), .multi_en_i(men), .pfx_supported_i(psup),
    .sts_wr_i(sts_wr), .unc_status_i(unc), .fep_o(nq_fep), .pfx_valid_o(nq_pv),
    .hdr_log_o(nq_h), .pfx_log_o(nq_p), .reassert_o(nq_re), .overflow_o(nq_ovf),
    .multi_cap_o(nq_cap));

  typedef struct {
    int            due;
    string         tag;
    logic [IW-1:0] fep;
    logic [127:0]  h, p;
    logic          pv;
    logic [SW-1:0] re;
    logic          ov;
  } exp_t;

  typedef struct {
    logic [SW-1:0] st;
    logic [127:0]  h, p;
    logic          hv, pp;
  } rec_t;

  exp_t sbq[$];
  rec_t mq[$];
  logic [IW-1:0] m_fep = '0;
  logic [127:0]  m_h = '0, m_p = '0;
  logic          m_pv = 0;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  function automatic logic [127:0] brev(input logic [127:0] d);
    logic [127:0] r;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        r[w*32 + (3-b)*8 +: 8] = d[w*32 + b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items once the design has had its clock edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.tag, "fep",      128'(fep),  128'(e.fep));
      chk(e.tag, "hdr_log",  hlog,       e.h);
      chk(e.tag, "pfx_log",  plog,       e.p);
      chk(e.tag, "pfx_valid",128'(pv),   128'(e.pv));
      chk(e.tag, "reassert", 128'(re),   128'(e.re));
      chk(e.tag, "overflow", 128'(ovf),  128'(e.ov));
    end
  end

  function automatic void m_load(input rec_t r);
    m_fep = '0;
    for (int i = SW-1; i >= 0; i--) if (r.st[i]) m_fep = IW'(i);
    m_h = r.hv ? brev(r.h) : '0;
    if (r.pp && psup) begin m_p = brev(r.p); m_pv = 1; end
    else begin m_p = '0; m_pv = 0; end
  endfunction

  task automatic push_exp(input string tag, input logic [SW-1:0] ere, input logic eov);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.fep = m_fep; e.h = m_h; e.p = m_p;
    e.pv = m_pv; e.re = ere; e.ov = eov;
    sbq.push_back(e);
  endtask

  task automatic do_rec(input rec_t r, input string tag);
    logic eov;
    eov = 0;
    if (men && unc[m_fep]) begin
      if (mq.size() == DEPTH) eov = 1;
      else mq.push_back(r);
    end else m_load(r);
    rec_st = r.st; rec_h = r.h; rec_p = r.p; hv = r.hv; pp = r.pp;
    rec_valid = 1;
    push_exp(tag, '0, eov);
    @(negedge clk);
    rec_valid = 0;
    unc = unc | r.st;
  endtask

  task automatic do_wr(input logic [SW-1:0] nst, input string tag);
    logic [SW-1:0] ere;
    ere = '0;
    unc = nst;
    if (!nst[m_fep]) begin
      if (men && mq.size() > 0) begin
        rec_t r;
        foreach (mq[i]) ere |= mq[i].st;
        r = mq.pop_front();
        m_load(r);
      end else begin
        m_fep = '0; m_h = '0; m_p = '0; m_pv = 0;
      end
    end else if (men) begin
      foreach (mq[i]) ere |= mq[i].st;
    end else mq.delete();
    sts_wr = 1;
    push_exp(tag, ere, 0);
    @(negedge clk);
    sts_wr = 0;
    unc = unc | ere;
  endtask

  function automatic rec_t mk(input int bitn, input logic h_ok, input logic p_ok);
    rec_t r;
    r.st = SW'(1) << bitn;
    r.h  = {4{32'h0 + bitn}} ^ 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    r.p  = {4{32'h0 + bitn}} ^ 128'hf0e0d0c0_b0a09080_70605040_30201000;
    r.hv = h_ok; r.pp = p_ok;
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "reset fep", 128'(fep), '0);
    chk("R12", "reset hdr", hlog, '0);
    chk("R12", "reset pfx", plog, '0);
    chk("R12", "reset flags", 128'({pv, ovf, re}), '0);
    // R10 capability
    chk("R10", "multi_cap depth8", 128'(cap), 128'(1));
    chk("R10", "multi_cap depth0", 128'(nq_cap), 128'(0));

    // R1 R2: header only, recording off
    do_rec(mk(4, 1, 0), "R2");
    // R3: prefix captured when supported; overwrites log since recording is off
    do_rec(mk(5, 1, 1), "R3");
    // R3: prefix dropped when unsupported; R2 header invalid gives zero
    psup = 0;
    do_rec(mk(6, 0, 1), "R3");
    psup = 1;
    // R7: clear pointed bit with empty queue
    do_wr('0, "R7");

    // R1 R4 R11: multiple recording
    men = 1;
    do_rec(mk(2, 1, 1), "R1");
    do_rec(mk(7, 1, 0), "R4");
    chk("R10", "no-queue variant loads", 128'(nq_fep), 128'(7));
    do_rec(mk(9, 0, 1), "R4");
    // R8: software tries to clear a queued bit while pointed bit pending
    do_wr(unc & ~(SW'(1) << 7), "R8");
    // R6: clear pointed bit, oldest queued promoted
    do_wr(unc & ~(SW'(1) << 2), "R6");

    // R5: fill queue to DEPTH then overflow
    for (int b = 10; b < 18; b++) do_rec(mk(b, 1, 0), "R5");
    do_rec(mk(18, 1, 1), "R5");
    // R11: in-order promotion (bit 9 next)
    do_wr(unc & ~(SW'(1) << 7), "R11");
    // R8 again with a larger queue
    do_wr(unc & ~(SW'(1) << 12), "R8");

    // R9: recording off, pointed bit left set -> flush
    men = 0;
    do_wr(unc, "R9");
    men = 1;
    do_wr('0, "R9");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule